// File: doc/BRIEF.md
# Bitfield Extract Unit

This block takes a 32-bit source operand and returns one contiguous bitfield of it, moved down so that the field's lowest bit lands at result bit 0. The field is given by two numbers: the index of its least significant bit in the source, and its length. The bit index comes either from the instruction's immediate or from the current value of a dedicated shift-amount register. A per-operation flag selects which one is used. The length always comes from the immediate.

The bits of the result above the field are filled with zeros (unsigned) or with copies of the field's top bit (signed). The block can also act as a right shifter. Setting the index to the shift count and the length to the remaining width gives a logical shift when unsigned and an arithmetic shift when signed.

A field that would run past source bit 31 is cut off there, so bit 31 becomes its top bit. Each operation is qualified by an input strobe. By default the result and a result-valid flag appear one clock later. A parameter can remove the output register and make the unit purely combinational.

Top module: `bfx_unit`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid and result are both 0 after that edge.
- R2: out_valid is 1 in the cycle after a cycle with in_valid high, and 0 in the cycle after a cycle with in_valid low.
- R3: After a cycle with in_valid low, result keeps the value it had, whatever the other inputs do.
- R4: With sign_en = 0, result equals (src >> P) AND a mask of L ones in the low bits. P is the selected position (0 to 31) and L is the effective length. Every result bit at index L or above is 0.
- R5: With sign_en = 1, result bits below L match R4. Every bit at index L or above equals src bit P+L-1.
- R6: With use_sar = 1, P is sar_pos and imm_pos has no effect on result. With use_sar = 0, P is imm_pos and sar_pos has no effect on result.
- R7: len_code values 1 to 31 request that many bits, and len_code = 0 requests 32 bits. With P = 0 and len_code = 0, result equals src.
- R8: The effective length L is the lesser of the requested length and 32 − P. When P = 31 the result is src bit 31 in the unsigned case. In the signed case it is 32 copies of src bit 31.
- R9: With P = s and requested length 32 − s, result equals src logically shifted right by s when sign_en = 0. It equals src arithmetically shifted right by s when sign_en = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe; the fields below are captured when high |
| src | input | 32 | Source operand |
| imm_pos | input | 5 | Field LSB index taken from the immediate |
| sar_pos | input | 5 | Field LSB index read from the shift-amount register |
| use_sar | input | 1 | 1 selects sar_pos, 0 selects imm_pos |
| len_code | input | 5 | Requested field length; 0 means 32 |
| sign_en | input | 1 | 1 fills upper result bits with the field's top bit, 0 fills with zeros |
| out_valid | output | 1 | Result-valid, one cycle after in_valid |
| result | output | 32 | Right-justified field |

## Verification
The properties assume that src, both position inputs, len_code, use_sar and sign_en hold known values in every cycle where in_valid is high. They also assume that reset is low at the first clock edge. The bench meets this by driving every input to a defined value at each falling edge, with the unused position input set to the complement of the selected one. It holds in_valid low while reset is asserted. The sweep steps through every position, every length code, both fill modes and both position sources for several source patterns. That covers all clipped fields and the full-width case.

// File: rtl/bfx_pkg.sv
// Shared types for the bitfield extract unit.
// Assumes nothing beyond a 1-bit fill selector.
package bfx_pkg;
    typedef enum logic {
        FILL_ZERO = 1'b0,
        FILL_SIGN = 1'b1
    } fill_e;
endpackage

// File: rtl/bfx_possel.sv
// Picks the field's LSB index from either the immediate or the
// shift-amount register value. Assumes both inputs are already valid.
module bfx_possel #(
    parameter int POS_W = 5
) (
    input  logic             use_sar,
    input  logic [POS_W-1:0] imm_pos,
    input  logic [POS_W-1:0] sar_pos,
    output logic [POS_W-1:0] pos
);
    // Select the position source.
    always_comb begin
        pos = use_sar ? sar_pos : imm_pos;
    end
endmodule

// File: rtl/bfx_lenclip.sv
// Turns the length code into an effective length clipped at the top of
// the word, then builds the low-aligned field mask and the index of the
// field's top bit. Assumes DATA_W is a power of two, equal to 2**POS_W.
module bfx_lenclip #(
    parameter int DATA_W = 32,
    parameter int POS_W  = 5
) (
    input  logic [POS_W-1:0]  pos,
    input  logic [POS_W-1:0]  len_code,
    output logic [DATA_W-1:0] mask,
    output logic [POS_W-1:0]  msb_idx
);
    localparam int LW = POS_W + 1;
    localparam logic [LW-1:0] FULL = LW'(DATA_W);

    logic [LW-1:0] len_req;
    logic [LW-1:0] room;
    logic [LW-1:0] eff_len;

    // Decode the length (code 0 = full width) and clip it to the space left.
    always_comb begin
        len_req = (len_code == '0) ? FULL : {1'b0, len_code};
        room    = FULL - {1'b0, pos};
        eff_len = (len_req > room) ? room : len_req;
        msb_idx = POS_W'(eff_len - LW'(1));
    end

    // One mask bit per result bit: set below the effective length.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign mask[i] = (LW'(i) < eff_len);
    end
endmodule

// File: rtl/bfx_align.sv
// Shifts the source down by the position, keeps the masked field and
// fills the bits above it with zero or the field's top bit.
// Assumes mask is a contiguous run of ones from bit 0 up to msb_idx.
module bfx_align
    import bfx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int POS_W  = 5
) (
    input  logic [DATA_W-1:0] src,
    input  logic [POS_W-1:0]  pos,
    input  logic [DATA_W-1:0] mask,
    input  logic [POS_W-1:0]  msb_idx,
    input  fill_e             fill,
    output logic [DATA_W-1:0] field
);
    logic [DATA_W-1:0] shifted;
    logic              top_bit;

    // Right-justify, mask, then apply the upper fill.
    always_comb begin
        shifted = src >> pos;
        top_bit = shifted[msb_idx];
        if (fill == FILL_SIGN && top_bit) begin
            field = (shifted & mask) | ~mask;
        end else begin
            field = shifted & mask;
        end
    end
endmodule

// File: rtl/bfx_unit.sv
// Top of the bitfield extract unit. Selects the position, clips the
// length, aligns the field and, when REG_OUT is 1, registers the result
// with a matching valid flag one cycle after in_valid.
// Assumes inputs are stable and known while in_valid is high.
module bfx_unit
    import bfx_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int REG_OUT = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [DATA_W-1:0]         src,
    input  logic [$clog2(DATA_W)-1:0] imm_pos,
    input  logic [$clog2(DATA_W)-1:0] sar_pos,
    input  logic                      use_sar,
    input  logic [$clog2(DATA_W)-1:0] len_code,
    input  logic                      sign_en,
    output logic                      out_valid,
    output logic [DATA_W-1:0]         result
);
    localparam int POS_W = $clog2(DATA_W);

    logic [POS_W-1:0]  pos;
    logic [DATA_W-1:0] mask;
    logic [POS_W-1:0]  msb_idx;
    logic [DATA_W-1:0] field;
    fill_e             fill;

    assign fill = fill_e'(sign_en);

    bfx_possel #(.POS_W(POS_W)) u_possel (
        .use_sar (use_sar),
        .imm_pos (imm_pos),
        .sar_pos (sar_pos),
        .pos     (pos)
    );

    bfx_lenclip #(.DATA_W(DATA_W), .POS_W(POS_W)) u_lenclip (
        .pos      (pos),
        .len_code (len_code),
        .mask     (mask),
        .msb_idx  (msb_idx)
    );

    bfx_align #(.DATA_W(DATA_W), .POS_W(POS_W)) u_align (
        .src     (src),
        .pos     (pos),
        .mask    (mask),
        .msb_idx (msb_idx),
        .fill    (fill),
        .field   (field)
    );

    if (REG_OUT != 0) begin : g_reg
        logic              vld_q;
        logic [DATA_W-1:0] res_q;

        // Capture the field on a valid operation; hold it otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                res_q <= '0;
            end else begin
                vld_q <= in_valid;
                if (in_valid) begin
                    res_q <= field;
                end
            end
        end
        assign out_valid = vld_q;
        assign result    = res_q;
    end else begin : g_comb
        assign out_valid = in_valid;
        assign result    = field;
    end
endmodule

// File: rtl/bfx_chk.sv
// Property checker for bfx_unit with the registered output. It watches
// only the ports and assumes in_valid stays low while reset is active.
module bfx_chk #(
    parameter int DATA_W  = 32,
    parameter int REG_OUT = 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [DATA_W-1:0]         src,
    input logic [$clog2(DATA_W)-1:0] imm_pos,
    input logic [$clog2(DATA_W)-1:0] sar_pos,
    input logic                      use_sar,
    input logic [$clog2(DATA_W)-1:0] len_code,
    input logic                      sign_en,
    input logic                      out_valid,
    input logic [DATA_W-1:0]         result
);
    localparam int POS_W = $clog2(DATA_W);
    logic [POS_W-1:0] sel_pos;
    assign sel_pos = use_sar ? sar_pos : imm_pos;

    if (REG_OUT != 0) begin : g_props
        AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!out_valid && result == '0)); // R1
        AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
        AST_VALID_CLR: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
        AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(result)); // R3
        AST_ZERO_FILL_LEN1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !sign_en && len_code == POS_W'(1)) |=> result[DATA_W-1:1] == '0); // R4
        AST_SIGN_FILL_LEN1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && sign_en && len_code == POS_W'(1)) |=> (result == '0 || &result)); // R5
        AST_FULL_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && sel_pos == '0 && len_code == '0) |=> result == $past(src)); // R7
        AST_CLIP_TOP_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && sign_en && sel_pos == POS_W'(DATA_W - 1)) |=> result == {DATA_W{$past(src[DATA_W-1])}}); // R8
    end
endmodule

bind bfx_unit bfx_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src       (src),
    .imm_pos   (imm_pos),
    .sar_pos   (sar_pos),
    .use_sar   (use_sar),
    .len_code  (len_code),
    .sign_en   (sign_en),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/sim_bfx_unit.sv
// Sweep bench for bfx_unit: every position, length code, fill mode and
// position source over several source words, plus reset and hold checks.
module sim_bfx_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] src = '0;
    logic [4:0]  imm_pos = '0;
    logic [4:0]  sar_pos = '0;
    logic        use_sar = 1'b0;
    logic [4:0]  len_code = '0;
    logic        sign_en = 1'b0;
    logic        out_valid;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bfx_unit #(.DATA_W(32), .REG_OUT(1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
        .imm_pos(imm_pos), .sar_pos(sar_pos), .use_sar(use_sar),
        .len_code(len_code), .sign_en(sign_en),
        .out_valid(out_valid), .result(result)
    );

    // Expected field from the requirements, using wide shifts and masks.
    function automatic logic [31:0] ref_fx(input logic [31:0] s, input int p,
                                           input int lc, input bit sg);
        int          len;
        int          eff;
        logic [63:0] m;
        logic [31:0] sh;
        logic [31:0] f;
        len = (lc == 0) ? 32 : lc;
        eff = (p + len > 32) ? 32 - p : len;
        m   = (64'd1 << eff) - 64'd1;
        sh  = s >> p;
        f   = sh & m[31:0];
        if (sg && sh[eff-1]) f = f | ~m[31:0];
        return f;
    endfunction

    function automatic string tag_of(input int p, input int lc, input bit sg, input bit v);
        int len;
        len = (lc == 0) ? 32 : lc;
        if (p == 0 && lc == 0) return "R7";
        if (p + len > 32)      return "R8";
        if (p + len == 32)     return "R9";
        if (v)                 return "R6";
        if (sg)                return "R5";
        return "R4";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one operation at a falling edge and check it one cycle later.
    task automatic run_op(input logic [31:0] s, input int p, input int lc,
                          input bit sg, input bit v);
        logic [31:0] exp;
        exp      = ref_fx(s, p, lc, sg);
        src      = s;
        use_sar  = v;
        imm_pos  = v ? ~5'(p) : 5'(p);
        sar_pos  = v ? 5'(p) : ~5'(p);
        len_code = 5'(lc);
        sign_en  = sg;
        in_valid = 1'b1;
        @(negedge clk);
        check(tag_of(p, lc, sg, v), result, exp);
        check("R2", {31'd0, out_valid}, 32'd1);
    endtask

    logic [31:0] pats [4];

    initial begin
        pats[0] = 32'hDEAD_BEEF;
        pats[1] = 32'h8000_0001;
        pats[2] = 32'h7FFF_FFFE;
        pats[3] = $urandom;

        repeat (3) @(negedge clk);
        check("R1", result, 32'd0);
        check("R1", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;

        for (int k = 0; k < 4; k++)
            for (int v = 0; v < 2; v++)
                for (int sg = 0; sg < 2; sg++)
                    for (int p = 0; p < 32; p++)
                        for (int lc = 0; lc < 32; lc++)
                            run_op(pats[k], p, lc, sg[0], v[0]);

        // Explicit shift cases, then hold after in_valid drops.
        run_op(32'h8000_00F0, 4, 28, 1'b0, 1'b0);
        check("R9", result, 32'h8000_00F0 >> 4);
        run_op(32'h8000_00F0, 4, 28, 1'b1, 1'b1);
        check("R9", result, 32'hF800_000F);
        run_op(32'hFFFF_FFFF, 31, 5, 1'b0, 1'b0);
        check("R8", result, 32'd1);

        in_valid = 1'b0;
        src      = 32'h1234_5678;
        imm_pos  = 5'd0;
        len_code = 5'd0;
        @(negedge clk);
        check("R3", result, 32'd1);
        check("R2", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        check("R3", result, 32'd1);

        for (int n = 0; n < 2000; n++)
            run_op($urandom, $urandom_range(31), $urandom_range(31),
                   1'($urandom_range(1)), 1'($urandom_range(1)));

        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check("R1", result, 32'd0);
        check("R1", {31'd0, out_valid}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule